// File: doc/BRIEF.md
# PHY Management Serial Controller

This block lets software reach the registers of an Ethernet PHY over the two-wire management bus (MDC clock, bidirectional MDIO data) using IEEE 802.3 clause 22 frames. Software sees one 32-bit command/status word. A single write to that word supplies the PHY address, the register address and the write data, and it can start a transfer. Software then polls the busy flag until the transfer ends. After a read the same word returns the 16-bit value from the PHY. A flag in the word reports a failed read, which happens when no PHY answered at the turnaround.

Inside, the block has three parts. The command/status register sits in the top module. A management clock divider produces MDC from the system clock, and it runs only while a transfer is active. A serial frame shifter drives MDIO after MDC falls and samples it when MDC rises. The MDIO pad is split into an output, an output enable and an input, so that the tristate buffer can be placed at the chip level.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset the word reads back with the PHY address field [15:11] equal to parameter PHY_ADDR_RST and every other bit 0. MDC is low and the MDIO output enable is low.
- R2: Word layout: [31:16] data, [15:11] PHY address, [10:6] register address, bit 0 write command, bit 1 read command, bit 3 busy, bit 4 read-not-valid. Bits 0, 1, 2 and 5 read back as 0. A write with neither command bit set only updates the data and address fields, and no frame is sent.
- R3: A write with bit 0 or bit 1 set, made while idle, sets busy from the next cycle. Busy stays set until the frame has ended.
- R4: A write frame is, MSB first: 32 ones, start 01, opcode 01, 5-bit PHY address, 5-bit register address, turnaround 10, then the 16 data bits. The controller drives all 64 bits.
- R5: A read frame uses opcode 10. The controller drives only its first 46 bits. It releases MDIO for the turnaround and the data. The 16 bits it samples are stored MSB first in [31:16].
- R6: Read-not-valid is set when the PHY does not hold MDIO low in the second turnaround bit of a read. A good read clears it.
- R7: MDC has a period of 2*MDC_HALF system clocks while a frame runs, and stays low while idle.
- R8: MDIO output changes only when MDC falls (or when a frame starts). Input is taken when MDC rises.
- R9: A write to the word while busy is set is ignored. The fields keep their values and no second frame follows.
- R10: With both command bits set, a read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the command/status word |
| wr_data | input | 32 | Value written to the word |
| rd_data | output | 32 | Current value of the word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the controller |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The bench builds the block with MDC_HALF = 2, so a full 64-bit frame takes 256 system clocks. This keeps good reads, failed reads, writes and ignored mid-frame writes all within a short run. PHY_ADDR_RST is set to 0x13, a value with both zero and one bits, so a wrong reset value or a field slipped by one bit shows up in the reset readback. The small divider also lets the bench check the exact MDC period and the falling-edge-only changes of MDIO on every bit of every frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_LEN  = 64;
    localparam int PRE_LEN    = 32;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    // bits driven by the controller in a read: preamble, start, opcode, two addresses
    localparam int RD_DRIVEN  = PRE_LEN + 2 + 2 + 2 * ADDR_W;
    localparam int TA2_IDX    = RD_DRIVEN + 1;
    localparam int DATA_IDX   = RD_DRIVEN + 2;
    localparam int CNT_W      = $clog2(FRAME_LEN + 1);

    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] ST_SYNC  = 2'b01;
    localparam logic [1:0] TA_WRITE = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int MDC_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_p,
    output logic fall_p
);
    localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_t;

    div_t d, q;

    always_comb begin
        d      = q;
        rise_p = 1'b0;
        fall_p = 1'b0;
        if (!en) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (q.cnt == CW'(MDC_HALF - 1)) begin
            d.cnt  = '0;
            d.mdc  = ~q.mdc;
            rise_p = ~q.mdc;
            fall_p = q.mdc;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc = q.mdc;

    // R7: clock parks low when disabled
    assert_mdc_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mdc);
endmodule

// File: rtl/mdio_shift.sv
module mdio_shift
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 is_read,
    input  logic [FRAME_LEN-1:0] frame,
    input  logic                 rise_p,
    input  logic                 fall_p,
    input  logic                 mdio_i,
    output logic                 active,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 done,
    output logic [DATA_W-1:0]    rdata,
    output logic                 ta_bad
);
    typedef struct packed {
        logic                 active;
        logic                 rd;
        logic [CNT_W-1:0]     cnt;
        logic [FRAME_LEN-1:0] sh;
        logic                 out;
        logic                 oe;
        logic [DATA_W-1:0]    rdata;
        logic                 ta_bad;
    } sh_t;

    sh_t d, q;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (start && !q.active) begin
            d.active = 1'b1;
            d.rd     = is_read;
            d.cnt    = '0;
            d.sh     = frame;
            d.out    = frame[FRAME_LEN-1];
            d.oe     = 1'b1;
            d.ta_bad = 1'b0;
        end else if (q.active) begin
            if (rise_p) begin
                if (q.rd && q.cnt == CNT_W'(TA2_IDX))
                    d.ta_bad = mdio_i;
                if (q.rd && q.cnt >= CNT_W'(DATA_IDX))
                    d.rdata = {q.rdata[DATA_W-2:0], mdio_i};
                d.cnt = q.cnt + 1'b1;
            end else if (fall_p) begin
                if (q.cnt == CNT_W'(FRAME_LEN)) begin
                    d.active = 1'b0;
                    d.out    = 1'b0;
                    d.oe     = 1'b0;
                    done     = 1'b1;
                end else begin
                    d.sh  = q.sh << 1;
                    d.out = q.sh[FRAME_LEN-2];
                    d.oe  = !q.rd || (q.cnt < CNT_W'(RD_DRIVEN));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active  = q.active;
    assign mdio_o  = q.out;
    assign mdio_oe = q.oe;
    assign rdata   = q.rdata;
    assign ta_bad  = q.ta_bad;

    // R8: output moves only on a falling management edge or at frame start
    assert_drive_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $past(fall_p || start));

    // R5: line released for turnaround and data of a read
    assert_release_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && q.rd && q.cnt > CNT_W'(RD_DRIVEN)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
    import mdio_pkg::*;
#(
    parameter int               MDC_HALF     = 4,
    parameter logic [ADDR_W-1:0] PHY_ADDR_RST = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic              busy;
        logic              nvalid;
        logic              rd;
    } reg_t;

    reg_t d, q;

    logic                 start, is_read, active, rise_p, fall_p, done, ta_bad;
    logic [DATA_W-1:0]    rdata;
    logic [FRAME_LEN-1:0] frame;
    logic                 unused_bits;

    assign unused_bits = ^wr_data[5:2];
    assign is_read     = wr_data[1];
    assign start       = wr_en && !q.busy && (wr_data[0] || wr_data[1]);
    assign frame       = {{PRE_LEN{1'b1}}, ST_SYNC, is_read ? OP_READ : OP_WRITE,
                          wr_data[15:11], wr_data[10:6], TA_WRITE, wr_data[31:16]};

    always_comb begin
        d = q;
        if (wr_en && !q.busy) begin
            d.data  = wr_data[31:16];
            d.phy   = wr_data[15:11];
            d.regad = wr_data[10:6];
            if (start) begin
                d.busy = 1'b1;
                d.rd   = is_read;
                if (is_read) d.nvalid = 1'b0;
            end
        end
        if (done) begin
            d.busy = 1'b0;
            if (q.rd) begin
                d.data   = rdata;
                d.nvalid = ta_bad;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.phy <= PHY_ADDR_RST;
        end else begin
            q <= d;
        end
    end

    assign rd_data = {q.data, q.phy, q.regad, 1'b0, q.nvalid, q.busy, 3'b000};

    mdio_clkgen #(.MDC_HALF(MDC_HALF)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (active),
        .mdc    (mdc),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    mdio_shift u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .is_read (is_read),
        .frame   (frame),
        .rise_p  (rise_p),
        .fall_p  (fall_p),
        .mdio_i  (mdio_i),
        .active  (active),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done    (done),
        .rdata   (rdata),
        .ta_bad  (ta_bad)
    );

    // R3: accepted command raises busy
    assert_busy_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && wr_en && (wr_data[0] || wr_data[1])) |=> rd_data[3]);

    // R9: addresses untouched by writes during a transfer
    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && wr_en) |=> ($stable(rd_data[15:11]) && $stable(rd_data[10:6])));

    // R3: the frame engine runs exactly while busy
    assert_active_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> q.busy);
endmodule

// File: tb/mdio_ctrl_tb.sv
module mdio_ctrl_tb;
    localparam int         HALF    = 2;
    localparam logic [4:0] RST_PHY = 5'h13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int          n_chk = 0, n_bad = 0;
    int          kcnt = 0, nframes = 0, cyc = 0, last_rise = 0, r8_viol = 0;
    logic [63:0] cap = '0, ocap = '0;
    logic        hold_o = 1'b0;
    logic        rd_mode = 1'b0, ta2_val = 1'b0;
    logic [15:0] resp = '0;
    logic [63:0] exp_frame_q[$];
    logic [63:0] exp_mask_q[$];

    always #2 clk = ~clk;  // 250 MHz

    mdio_ctrl #(.MDC_HALF(HALF), .PHY_ADDR_RST(RST_PHY)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (mdc && mdio_o !== hold_o) r8_viol++;
    end

    // PHY model and scoreboard monitor
    always @(posedge mdc) begin
        logic [63:0] ef, em;
        hold_o = mdio_o;
        cap  = {cap[62:0], mdio_o};
        ocap = {ocap[62:0], mdio_oe};
        if (kcnt == 2) check((cyc - last_rise) == 2 * HALF, "R7 mdc period", cyc - last_rise, 2 * HALF);
        last_rise = cyc;
        kcnt++;
        if (kcnt == 64) begin
            nframes++;
            if (exp_frame_q.size() == 0) begin
                check(1'b0, "R9 unexpected frame", cap, 0);
            end else begin
                ef = exp_frame_q.pop_front();
                em = exp_mask_q.pop_front();
                check((cap & em) == (ef & em), "R4/R5 frame bits", cap & em, ef & em);
                check(ocap == em, "R5 drive enable pattern", ocap, em);
            end
        end
    end

    always @(negedge mdc) begin
        if (rd_mode && kcnt == 47)                  mdio_i = ta2_val;
        else if (rd_mode && kcnt >= 48 && kcnt <= 63) mdio_i = resp[63 - kcnt];
        else                                        mdio_i = 1'b1;
    end

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_frame(input logic [31:0] w, input bit rd);
        logic [63:0] f;
        f = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, w[15:11], w[10:6], 2'b10, w[31:16]};
        exp_frame_q.push_back(f);
        exp_mask_q.push_back(rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}});
        kcnt = 0;
        rd_mode = rd;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (rd_data[3] && t < 2000) begin @(negedge clk); t++; end
        repeat (2 * HALF + 2) @(negedge clk);
    endtask

    task automatic do_read(input logic [31:0] w, input logic [15:0] r, input logic ta2);
        resp = r; ta2_val = ta2;
        expect_frame(w, 1'b1);
        issue(w);
        wait_idle();
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] w;
        int nf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rd_data == {16'h0, RST_PHY, 11'h0}, "R1 reset word", rd_data, {16'h0, RST_PHY, 11'h0});
        check(!mdc && !mdio_oe, "R1 idle pins", {mdc, mdio_oe}, 0);

        // R2 field update without command
        w = {16'hBEEF, 5'h0A, 5'h11, 6'b000000};
        issue(w);
        check(rd_data == w, "R2 field readback", rd_data, w);
        repeat (20) @(negedge clk);
        check(nframes == 0 && !mdc, "R2 no frame / R7 idle low", nframes, 0);

        // R3 R4 write
        w = {16'hA5C3, 5'h03, 5'h1F, 6'b000001};
        expect_frame(w, 1'b0);
        @(negedge clk); wr_en = 1'b1; wr_data = w;
        @(negedge clk); wr_en = 1'b0;
        check(rd_data[3] == 1'b1, "R3 busy after start", rd_data[3], 1);
        repeat (100) @(negedge clk);
        check(rd_data[3] == 1'b1, "R3 busy mid frame", rd_data[3], 1);
        wait_idle();
        check(nframes == 1, "R4 one write frame", nframes, 1);
        check(rd_data == {16'hA5C3, 5'h03, 5'h1F, 6'b0}, "R4 word after write", rd_data, {16'hA5C3, 5'h03, 5'h1F, 6'b0});

        // R5 good read
        do_read({16'h0, 5'h07, 5'h02, 6'b000010}, 16'h1234, 1'b0);
        check(rd_data[31:16] == 16'h1234, "R5 read data", rd_data[31:16], 16'h1234);
        check(rd_data[4] == 1'b0, "R6 good read valid", rd_data[4], 0);

        // R6 missing PHY
        do_read({16'h0, 5'h1C, 5'h05, 6'b000010}, 16'hFFFF, 1'b1);
        check(rd_data[4] == 1'b1, "R6 not-valid set", rd_data[4], 1);
        do_read({16'h0, 5'h01, 5'h1A, 6'b000010}, 16'h0F0F, 1'b0);
        check(rd_data[4] == 1'b0, "R6 not-valid cleared", rd_data[4], 0);
        check(rd_data[31:16] == 16'h0F0F, "R5 second read data", rd_data[31:16], 16'h0F0F);

        // R10 both command bits -> read
        do_read({16'h5555, 5'h09, 5'h03, 6'b000011}, 16'h8001, 1'b0);
        check(rd_data[31:16] == 16'h8001, "R10 read wins", rd_data[31:16], 16'h8001);

        // R9 write while busy
        nf = nframes;
        w = {16'h7E81, 5'h12, 5'h0C, 6'b000001};
        expect_frame(w, 1'b0);
        issue(w);
        repeat (30) @(negedge clk);
        issue({16'h1111, 5'h1E, 5'h01, 6'b000010});
        wait_idle();
        repeat (300) @(negedge clk);
        check(nframes == nf + 1, "R9 single frame", nframes, nf + 1);
        check(rd_data == {16'h7E81, 5'h12, 5'h0C, 6'b0}, "R9 fields kept", rd_data, {16'h7E81, 5'h12, 5'h0C, 6'b0});

        // R8 output only changes on falling edge
        check(r8_viol == 0, "R8 drive on fall", r8_viol, 0);
        check(exp_frame_q.size() == 0, "R4 all frames seen", exp_frame_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule